// File: doc/BRIEF.md
# Multi-Queue Shared-Buffer FIFO Controller

This block keeps up to eight independent first-in first-out queues inside one shared word memory. Every queue owns a contiguous region of that memory, described by a base address, a depth and two flag thresholds. One write port and one read port serve all queues. Each port carries its own queue address, so a word is steered into the queue named on the write side, and the read side presents the oldest word of the queue it names. The two ports work independently. They may name different queues, or the same queue in the same cycle.

The layout is captured while master reset is low. It comes either from the parallel configuration inputs or from a built-in default that splits the memory evenly across all queues. The selected queues report full (write side) and output-valid (read side). Near-full and near-empty bits for every queue are driven at all times on two flag vectors. A partial reset empties a single queue, but only when both ports address it.

The read path is show-ahead. `rd_data` shows the oldest word of the addressed queue whenever `rd_valid` is high. A read strobe removes that word at the clock edge. Everything runs on one clock.

Top module: `mq_fifo_ctrl`

## Requirements
- R1: When `cfg_use_default` is high during master reset, all NUM_Q queues are active. Queue i starts at word i*(MEM_WORDS/NUM_Q) and holds MEM_WORDS/NUM_Q words (64 with defaults). Both flag gaps are DEF_AF / DEF_AE (8).
- R2: When `cfg_use_default` is low, the active queue count, bases, depths and gaps are taken from the configuration inputs on clock edges while `rst_n` is low. A count of 0 is raised to 1 and a count above NUM_Q is lowered to NUM_Q. Queue i uses slices [i*AW +: AW] of `cfg_base` and [i*CW +: CW] of the other vectors. Changes to these inputs while `rst_n` is high have no effect.
- R3: Words written to a queue are read back from that queue in write order, unaffected by traffic to other queues.
- R4: `wr_full` is high when the write-addressed queue holds its full depth. A write strobe while `wr_full` is high stores nothing and moves no pointer.
- R5: `rd_valid` is high when the read-addressed queue holds at least one word, and `rd_data` then shows its oldest word. A read strobe while `rd_valid` is low changes nothing.
- R6: A write and a read to the same queue in one cycle both take effect, leaving the occupancy unchanged. If that queue is full, only the read takes effect. If it is empty, only the write takes effect.
- R7: For every queue i, whether selected or not, `almost_full[i]` is high when depth minus occupancy is at most its near-full gap. `almost_empty[i]` is high when occupancy is at most its near-empty gap.
- R8: Queues at or above the active count read as inactive. For such a queue `wr_full` is 1 and `rd_valid` is 0 when it is addressed, `almost_full` is 0 and `almost_empty` is 1, and writes and reads to it are ignored.
- R9: If `prst` is high and `wr_q` equals `rd_q`, that queue is empty after the edge, no write or read happens in that cycle, and other queues keep their contents. If the addresses differ, `prst` has no effect and normal traffic proceeds.
- R10: Master reset empties every queue: afterwards `rd_valid` is 0, `almost_empty` is all ones and `almost_full` all zeros.
- R11: Each queue's pointers wrap inside its own region. Data that crosses the end of the region is returned intact, and neighbouring regions are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low; configuration is captured while low |
| cfg_use_default | input | 1 | Select the built-in even layout instead of the configuration inputs |
| cfg_num_q | input | QCW | Requested number of active queues |
| cfg_base | input | NUM_Q*AW | Per-queue region base address |
| cfg_size | input | NUM_Q*CW | Per-queue depth in words (at least 1) |
| cfg_af_gap | input | NUM_Q*CW | Per-queue near-full gap |
| cfg_ae_gap | input | NUM_Q*CW | Per-queue near-empty gap |
| wr_en | input | 1 | Write strobe |
| wr_q | input | QW | Queue addressed by the write port |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read strobe |
| rd_q | input | QW | Queue addressed by the read port |
| rd_data | output | DATA_W | Oldest word of the read-addressed queue |
| prst | input | 1 | Partial reset request |
| wr_full | output | 1 | Write-addressed queue cannot accept a word |
| rd_valid | output | 1 | Read-addressed queue holds a word |
| almost_full | output | NUM_Q | Per-queue near-full flags |
| almost_empty | output | NUM_Q | Per-queue near-empty flags |

## Verification
The bench keeps the default sizes: 18-bit words, 512 words of memory, eight queues and gaps of 8. It first resets with the even layout, where 64-deep queues let it reach the full boundary, near-full flags and pointer wrap with every queue active. It then resets again with a three-queue custom layout of depths 5, 300 and 7. The short queues reach full and wrap within a few cycles, and the five unused queues exercise inactive-queue handling. This layout also shows that configuration inputs changed after reset are ignored.

// File: rtl/mq_pkg.sv
package mq_pkg;

  // Advance a region offset by one, returning to zero past the last slot.
  function automatic int unsigned mq_step(int unsigned off, int unsigned size);
    if (off + 1 >= size) return 0;
    return off + 1;
  endfunction

  // Near-full: free space no larger than the gap.
  function automatic logic mq_near_full(int unsigned cnt, int unsigned size,
                                        int unsigned gap);
    return (cnt + gap >= size);
  endfunction

  // Near-empty: occupancy no larger than the gap.
  function automatic logic mq_near_empty(int unsigned cnt, int unsigned gap);
    return (cnt <= gap);
  endfunction

  // Keep a requested queue count inside 1..maxq.
  function automatic int unsigned mq_clamp_count(int unsigned req, int unsigned maxq);
    if (req == 0) return 1;
    if (req > maxq) return maxq;
    return req;
  endfunction

endpackage

// File: rtl/mq_cfg_regs.sv
module mq_cfg_regs
  import mq_pkg::*;
#(
  parameter int NUM_Q     = 8,
  parameter int MEM_WORDS = 512,
  parameter int DEF_AF    = 8,
  parameter int DEF_AE    = 8,
  parameter int AW        = 9,
  parameter int CW        = 10,
  parameter int QCW       = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_use_default,
  input  logic [QCW-1:0]        cfg_num_q,
  input  logic [NUM_Q*AW-1:0]   cfg_base,
  input  logic [NUM_Q*CW-1:0]   cfg_size,
  input  logic [NUM_Q*CW-1:0]   cfg_af_gap,
  input  logic [NUM_Q*CW-1:0]   cfg_ae_gap,
  output logic [NUM_Q-1:0]      q_active,
  output logic [AW-1:0]         q_base   [NUM_Q],
  output logic [CW-1:0]         q_size   [NUM_Q],
  output logic [CW-1:0]         q_af_gap [NUM_Q],
  output logic [CW-1:0]         q_ae_gap [NUM_Q]
);

  localparam int SLICE = MEM_WORDS / NUM_Q;

  logic [QCW-1:0] num_r;

  // Active count is sampled on every edge while master reset is low.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (cfg_use_default) num_r <= QCW'(NUM_Q);
      else num_r <= QCW'(mq_clamp_count(32'(cfg_num_q), 32'(NUM_Q)));
    end
  end

  for (genvar i = 0; i < NUM_Q; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        if (cfg_use_default) begin
          q_base[i]   <= AW'(i * SLICE);
          q_size[i]   <= CW'(SLICE);
          q_af_gap[i] <= CW'(DEF_AF);
          q_ae_gap[i] <= CW'(DEF_AE);
        end else begin
          q_base[i]   <= cfg_base[i*AW +: AW];
          q_size[i]   <= cfg_size[i*CW +: CW];
          q_af_gap[i] <= cfg_af_gap[i*CW +: CW];
          q_ae_gap[i] <= cfg_ae_gap[i*CW +: CW];
        end
      end
    end

    assign q_active[i] = (32'(num_r) > i);

    if (i < NUM_Q - 1) begin : g_prefix
      // R8: active queues form a contiguous run starting at queue 0
      p_active_prefix_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !q_active[i] |-> !q_active[i+1]);
    end
  end

  // R2: at least one queue is always active after reset
  p_min_one_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_active[0]);

  // R2: layout is frozen once reset has been released
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(num_r) && $stable(q_size[0]) && $stable(q_base[0]));

endmodule

// File: rtl/mq_qstate.sv
module mq_qstate
  import mq_pkg::*;
#(
  parameter int AW = 9,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [CW-1:0] size,
  input  logic [CW-1:0] af_gap,
  input  logic [CW-1:0] ae_gap,
  input  logic          push,
  input  logic          pop,
  input  logic          clear,
  output logic [AW-1:0] wr_off,
  output logic [AW-1:0] rd_off,
  output logic          full,
  output logic          empty,
  output logic          near_full,
  output logic          near_empty
);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clear) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= AW'(mq_step(32'(wptr), 32'(size)));
      if (pop)  rptr <= AW'(mq_step(32'(rptr), 32'(size)));
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign wr_off     = wptr;
  assign rd_off     = rptr;
  assign full       = !active || (cnt >= size);
  assign empty      = !active || (cnt == '0);
  assign near_full  = active && mq_near_full(32'(cnt), 32'(size), 32'(af_gap));
  assign near_empty = !active || mq_near_empty(32'(cnt), 32'(ae_gap));

  // R4: the write gate never lets a word into a full queue
  p_push_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R4: occupancy never exceeds the configured depth
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= size);

  // R5: the read gate never pops an empty queue
  p_pop_not_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R6: a simultaneous push and pop leave the occupancy unchanged
  p_hold_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !clear |=> cnt == $past(cnt));

  // R9: a partial reset leaves the queue empty
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0 && wptr == rptr);

  // R11: pointers stay inside the region
  p_ptr_in_region_r11: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (CW'(wptr) < size) && (CW'(rptr) < size));

endmodule

// File: rtl/mq_buffer.sv
module mq_buffer #(
  parameter int DATA_W    = 18,
  parameter int MEM_WORDS = 512,
  parameter int AW        = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [MEM_WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/mq_fifo_ctrl.sv
module mq_fifo_ctrl
  import mq_pkg::*;
#(
  parameter int DATA_W    = 18,
  parameter int MEM_WORDS = 512,
  parameter int NUM_Q     = 8,
  parameter int DEF_AF    = 8,
  parameter int DEF_AE    = 8,
  localparam int AW       = $clog2(MEM_WORDS),
  localparam int CW       = AW + 1,
  localparam int QW       = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int QCW      = $clog2(NUM_Q + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_use_default,
  input  logic [QCW-1:0]      cfg_num_q,
  input  logic [NUM_Q*AW-1:0] cfg_base,
  input  logic [NUM_Q*CW-1:0] cfg_size,
  input  logic [NUM_Q*CW-1:0] cfg_af_gap,
  input  logic [NUM_Q*CW-1:0] cfg_ae_gap,
  input  logic                wr_en,
  input  logic [QW-1:0]       wr_q,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [QW-1:0]       rd_q,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                prst,
  output logic                wr_full,
  output logic                rd_valid,
  output logic [NUM_Q-1:0]    almost_full,
  output logic [NUM_Q-1:0]    almost_empty
);

  logic [NUM_Q-1:0] q_active, q_full, q_empty, q_nf, q_ne;
  logic [NUM_Q-1:0] push_vec, pop_vec, clr_vec;
  logic [AW-1:0]    q_base [NUM_Q];
  logic [CW-1:0]    q_size [NUM_Q];
  logic [CW-1:0]    q_afg  [NUM_Q];
  logic [CW-1:0]    q_aeg  [NUM_Q];
  logic [AW-1:0]    q_woff [NUM_Q];
  logic [AW-1:0]    q_roff [NUM_Q];

  // Named internal events
  logic          prst_hit;
  logic          wr_accept;
  logic          rd_accept;
  logic          sel_wr_full;
  logic          sel_rd_empty;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;

  mq_cfg_regs #(
    .NUM_Q(NUM_Q), .MEM_WORDS(MEM_WORDS), .DEF_AF(DEF_AF), .DEF_AE(DEF_AE),
    .AW(AW), .CW(CW), .QCW(QCW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_use_default(cfg_use_default),
    .cfg_num_q(cfg_num_q), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_af_gap(cfg_af_gap), .cfg_ae_gap(cfg_ae_gap),
    .q_active(q_active), .q_base(q_base), .q_size(q_size),
    .q_af_gap(q_afg), .q_ae_gap(q_aeg)
  );

  assign sel_wr_full  = q_full[wr_q];
  assign sel_rd_empty = q_empty[rd_q];
  assign prst_hit     = prst && (wr_q == rd_q);
  assign wr_accept    = wr_en && !prst_hit && !sel_wr_full;
  assign rd_accept    = rd_en && !prst_hit && !sel_rd_empty;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    assign push_vec[i] = wr_accept && (wr_q == QW'(i));
    assign pop_vec[i]  = rd_accept && (rd_q == QW'(i));
    assign clr_vec[i]  = prst_hit && (wr_q == QW'(i));

    mq_qstate #(.AW(AW), .CW(CW)) u_qs (
      .clk(clk), .rst_n(rst_n), .active(q_active[i]),
      .size(q_size[i]), .af_gap(q_afg[i]), .ae_gap(q_aeg[i]),
      .push(push_vec[i]), .pop(pop_vec[i]), .clear(clr_vec[i]),
      .wr_off(q_woff[i]), .rd_off(q_roff[i]),
      .full(q_full[i]), .empty(q_empty[i]),
      .near_full(q_nf[i]), .near_empty(q_ne[i])
    );
  end

  assign wr_addr = q_base[wr_q] + q_woff[wr_q];
  assign rd_addr = q_base[rd_q] + q_roff[rd_q];

  mq_buffer #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS), .AW(AW)) u_buf (
    .clk(clk), .we(wr_accept), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign wr_full      = sel_wr_full;
  assign rd_valid     = !sel_rd_empty;
  assign almost_full  = q_nf;
  assign almost_empty = q_ne;

  // R3: at most one queue is written and at most one is read per cycle
  p_one_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push_vec) && $onehot0(pop_vec));

  // R9: a partial reset blocks all traffic in its cycle
  p_prst_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prst_hit |-> push_vec == '0 && pop_vec == '0 && $onehot(clr_vec));

  // R8: an inactive write target reports full
  p_inactive_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !q_active[wr_q] |-> wr_full && !push_vec[wr_q]);

  // R7: an inactive queue never reports near-full
  p_inactive_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (almost_full & ~q_active) == '0 && (almost_empty | q_active) == '1);

  // R10: straight after master reset nothing is readable
  p_reset_empty_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> !rd_valid && almost_full == '0);

endmodule

// File: tb/mq_fifo_ctrl_bench.sv
module mq_fifo_ctrl_bench;

  localparam int DW = 18;
  localparam int NQ = 8;
  localparam int AW = 9;
  localparam int CW = 10;
  localparam int PERIOD = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_use_default = 1'b1;
  logic [3:0]    cfg_num_q = '0;
  logic [NQ*AW-1:0] cfg_base = '0;
  logic [NQ*CW-1:0] cfg_size = '0, cfg_af_gap = '0, cfg_ae_gap = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0, prst = 1'b0;
  logic [2:0]    wr_q = '0, rd_q = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_full, rd_valid;
  logic [NQ-1:0] almost_full, almost_empty;

  mq_fifo_ctrl u_mq_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_use_default(cfg_use_default),
    .cfg_num_q(cfg_num_q), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_af_gap(cfg_af_gap), .cfg_ae_gap(cfg_ae_gap),
    .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
    .rd_en(rd_en), .rd_q(rd_q), .rd_data(rd_data), .prst(prst),
    .wr_full(wr_full), .rd_valid(rd_valid),
    .almost_full(almost_full), .almost_empty(almost_empty)
  );

  always #(PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Scoreboard: expected contents per queue and the layout in force.
  logic [DW-1:0] sb [NQ][$];
  int m_size [NQ];
  int m_af   [NQ];
  int m_ae   [NQ];
  int m_nq;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_flags();
    logic [NQ-1:0] ef, ee;
    for (int i = 0; i < NQ; i++) begin
      int c = sb[i].size();
      ef[i] = (i < m_nq) && ((m_size[i] - c) <= m_af[i]);
      ee[i] = (i >= m_nq) || (c <= m_ae[i]);
    end
    check(almost_full == ef, "R7", "almost_full", almost_full, ef);
    check(almost_empty == ee, "R7", "almost_empty", almost_empty, ee);
  endtask

  // Driver: applies one cycle of stimulus, compares the visible state with
  // the scoreboard, then pushes/pops expected items for what the edge does.
  task automatic cyc(input bit we, input int wq, input int wd, input bit re,
                     input int rq, input bit pr, input string tag);
    bit exp_full, exp_valid, hit, wacc, racc;
    @(negedge clk);
    wr_en = we; wr_q = 3'(wq); wr_data = DW'(wd);
    rd_en = re; rd_q = 3'(rq); prst = pr;
    #1;
    exp_full  = (wq >= m_nq) || (sb[wq].size() == m_size[wq]);
    exp_valid = (rq < m_nq) && (sb[rq].size() > 0);
    check(wr_full == exp_full, tag, "wr_full", wr_full, exp_full);
    check(rd_valid == exp_valid, tag, "rd_valid", rd_valid, exp_valid);
    if (exp_valid)
      check(rd_data == sb[rq][0], tag, "rd_data", rd_data, sb[rq][0]);
    check_flags();
    hit  = pr && (wq == rq);
    wacc = we && !hit && !exp_full;
    racc = re && !hit && exp_valid;
    @(posedge clk);
    if (hit) sb[wq].delete();
    if (racc) void'(sb[rq].pop_front());
    if (wacc) sb[wq].push_back(DW'(wd));
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; rd_en = 0; prst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NQ; i++) sb[i].delete();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // ---- default layout ----
    cfg_use_default = 1'b1;
    m_nq = NQ;
    for (int i = 0; i < NQ; i++) begin m_size[i] = 64; m_af[i] = 8; m_ae[i] = 8; end
    do_reset();
    #1;
    check(rd_valid == 1'b0, "R10", "rd_valid after reset", rd_valid, 0);
    check(almost_empty == 8'hFF, "R10", "almost_empty after reset", almost_empty, 8'hFF);
    check(almost_full == 8'h00, "R10", "almost_full after reset", almost_full, 0);
    idle("R10");

    // R1 / R4: queue 3 takes exactly 64 words, the 65th is refused
    for (int k = 0; k < 64; k++) cyc(1, 3, 'h1000 + k, 0, 0, 0, "R1");
    cyc(1, 3, 'h3FFFF, 0, 0, 0, "R4");
    // R3: drain in order, R5: extra read refused
    for (int k = 0; k < 64; k++) cyc(0, 0, 0, 1, 3, 0, "R3");
    cyc(0, 0, 0, 1, 3, 0, "R5");
    idle("R5");

    // R3: interleaved writes across all queues, reads in another order
    for (int k = 0; k < 16; k++) cyc(1, k % 8, 'h2000 + k, 0, 0, 0, "R3");
    for (int q = 7; q >= 0; q--) begin
      cyc(0, 0, 0, 1, q, 0, "R3");
      cyc(0, 0, 0, 1, q, 0, "R3");
    end

    // R6: same-queue write and read together
    for (int k = 0; k < 3; k++) cyc(1, 1, 'h3000 + k, 0, 0, 0, "R6");
    for (int k = 0; k < 10; k++) cyc(1, 1, 'h3100 + k, 1, 1, 0, "R6");
    cyc(1, 2, 'h3200, 1, 2, 0, "R6");   // empty: write only
    cyc(0, 0, 0, 1, 2, 0, "R6");
    for (int k = 0; k < 64; k++) cyc(1, 6, 'h3300 + k, 0, 0, 0, "R6");
    cyc(1, 6, 'h3AAA, 1, 6, 0, "R6");   // full: read only
    cyc(1, 6, 'h3BBB, 1, 6, 0, "R6");
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 1, 0, "R6");
    for (int k = 0; k < 64; k++) cyc(0, 0, 0, 1, 6, 0, "R6");

    // R11: queue 5 wraps past its region end while queue 4 stays intact
    for (int k = 0; k < 3; k++) cyc(1, 4, 'h4000 + k, 0, 0, 0, "R11");
    for (int k = 0; k < 90; k++) begin
      cyc(1, 5, 'h5000 + k, 0, 0, 0, "R11");
      cyc(0, 0, 0, 1, 5, 0, "R11");
    end
    for (int k = 0; k < 50; k++) cyc(1, 5, 'h5800 + k, 0, 0, 0, "R11");
    for (int k = 0; k < 50; k++) cyc(0, 0, 0, 1, 5, 0, "R11");
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 4, 0, "R11");

    // R9: partial reset with both ports on queue 2
    for (int k = 0; k < 10; k++) cyc(1, 2, 'h6000 + k, 0, 0, 0, "R9");
    for (int k = 0; k < 5; k++) cyc(1, 4, 'h6100 + k, 0, 0, 0, "R9");
    cyc(1, 2, 'h6FFF, 1, 2, 1, "R9");
    idle("R9");
    cyc(0, 0, 0, 1, 2, 0, "R9");
    // R9: differing addresses, prst ignored, traffic proceeds
    for (int k = 0; k < 4; k++) cyc(1, 2, 'h6200 + k, 0, 0, 0, "R9");
    cyc(1, 2, 'h6300, 1, 4, 1, "R9");
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 1, 2, 0, "R9");
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 4, 0, "R9");

    // ---- custom layout: 3 queues of depth 5, 300, 7 ----
    cfg_use_default = 1'b0;
    cfg_num_q = 4'd3;
    cfg_base = '0; cfg_size = '0; cfg_af_gap = '0; cfg_ae_gap = '0;
    cfg_base[0*AW +: AW] = 9'd0;   cfg_size[0*CW +: CW] = 10'd5;
    cfg_af_gap[0*CW +: CW] = 10'd1; cfg_ae_gap[0*CW +: CW] = 10'd2;
    cfg_base[1*AW +: AW] = 9'd5;   cfg_size[1*CW +: CW] = 10'd300;
    cfg_af_gap[1*CW +: CW] = 10'd10; cfg_ae_gap[1*CW +: CW] = 10'd0;
    cfg_base[2*AW +: AW] = 9'd305; cfg_size[2*CW +: CW] = 10'd7;
    cfg_af_gap[2*CW +: CW] = 10'd2; cfg_ae_gap[2*CW +: CW] = 10'd3;
    m_nq = 3;
    m_size[0] = 5;   m_af[0] = 1;  m_ae[0] = 2;
    m_size[1] = 300; m_af[1] = 10; m_ae[1] = 0;
    m_size[2] = 7;   m_af[2] = 2;  m_ae[2] = 3;
    do_reset();
    // R2: later changes on the configuration inputs are ignored
    cfg_use_default = 1'b1;
    cfg_num_q = 4'd8;
    cfg_size = '1;
    idle("R10");
    for (int k = 0; k < 6; k++) cyc(1, 0, 'h7000 + k, 0, 0, 0, "R2");
    for (int k = 0; k < 6; k++) cyc(0, 0, 0, 1, 0, 0, "R2");
    for (int k = 0; k < 301; k++) cyc(1, 1, 'h8000 + k, 0, 0, 0, "R2");
    for (int k = 0; k < 300; k++) cyc(0, 0, 0, 1, 1, 0, "R2");

    // R8: inactive queues refuse traffic and report fixed flags
    for (int q = 3; q < NQ; q++) begin
      cyc(1, q, 'h9000 + q, 1, q, 0, "R8");
      cyc(0, 0, 0, 1, q, 0, "R8");
    end

    // R11: the 7-deep queue wraps
    for (int k = 0; k < 7; k++) cyc(1, 2, 'hA000 + k, 0, 0, 0, "R11");
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 2, 0, "R11");
    for (int k = 0; k < 5; k++) cyc(1, 2, 'hA100 + k, 0, 0, 0, "R11");
    for (int k = 0; k < 8; k++) cyc(0, 0, 0, 1, 2, 0, "R11");
    idle("R11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule